// File: doc/BRIEF.md
# Multi-Line Shared Receive Silo

The block gathers characters received on up to eight serial lines into a single first-in first-out store. The host reaches that store through one read word. Each entry records the character, the number of the line it came from, and three error flags: overrun, framing error and parity error. A line deserialiser raises a one-cycle strobe together with the character and its error bits. Only lines whose receive-enable bit is set have their characters taken. Each line has a one-deep holding stage. A fixed-priority arbiter moves one held character per cycle into the shared store.

The host reads the head entry as a combinational word. It raises a one-cycle pop strobe to consume that entry. It drains the store by reading until the valid flag drops. The interrupt request has two modes. In the plain mode it follows the fill level: it is raised whenever the store is non-empty. In the alarm mode it stays low until a set number of characters has gathered, which lets the host take them in one batch.

Top module: `mux_rx_silo`

## Requirements
- R1: The read word is 16 bits. Bits 7:0 hold the character, bits 10:8 hold the source line number, bit 11 reads zero, bit 12 is the parity-error flag, bit 13 is the framing-error flag, bit 14 is the overrun flag and bit 15 is the valid flag. When the store is empty the whole word reads zero.
- R2: After reset the read word is zero and the interrupt request is low.
- R3: The store holds 64 entries in total, shared by all lines, and its fill level never exceeds 64.
- R4: A pop while the valid flag is set removes exactly one entry. Entries leave in the order they entered the store.
- R5: A pop while the store is empty changes nothing. Characters written afterwards come out normally.
- R6: A strobe on a line whose receive-enable bit is clear is ignored, and no entry is made.
- R7: When several lines strobe in the same cycle, their characters enter the store lowest line number first.
- R8: A character that reaches a full store is dropped, unless a pop happens in the same cycle. The next entry written carries the overrun flag. Entries written after that one do not carry it.
- R9: With alarm mode off, the interrupt request is high exactly when receive interrupts are enabled and the store is non-empty.
- R10: With alarm mode on, the interrupt request stays low until at least 16 entries are stored, and is high from then on while receive interrupts are enabled.
- R11: The framing-error and parity-error bits given with a character are stored with it. A break is delivered as character 0x00 with the framing-error flag set.
- R12: If a line strobes again while its previous character is still waiting in the holding stage, the newer character replaces the older one and carries the overrun flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 8 | Per-line received-character strobe |
| line_char | input | 64 | Per-line character, line i in bits 8i+7:8i |
| line_ferr | input | 8 | Per-line framing-error bit for the strobed character |
| line_perr | input | 8 | Per-line parity-error bit for the strobed character |
| rx_enable | input | 8 | Per-line receive enable |
| rxint_en | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Alarm mode: defer interrupt until the threshold is reached |
| pop | input | 1 | Read strobe, consumes the head entry |
| rd_word | output | 16 | Head entry word |
| irq | output | 1 | Receive interrupt request |

## Verification
Two events can meet in one cycle: a character leaving the arbiter for the store, and the host popping the head entry. At the full boundary this decides whether the character is kept or dropped. The bench first fills the store to 64 entries. It then strobes a character timed so that its grant falls in the same cycle as a pop. The scoreboard expects that character to be kept, without the overrun flag, behind the 63 remaining older entries. The same bench also times a character into a full store with no pop. It then expects that character to be missing and the next entry written to carry the overrun flag.

// File: rtl/silo_pkg.sv
package silo_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 3;
  localparam int WORD_W = CHAR_W + LINE_W + 5;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } silo_entry_t;

  localparam int ENTRY_W = $bits(silo_entry_t);
endpackage

// File: rtl/silo_line_hold.sv
module silo_line_hold
  import silo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              grant,
  input  logic [CHAR_W-1:0] ch_in,
  input  logic              fe_in,
  input  logic              pe_in,
  output logic              pending,
  output logic [CHAR_W-1:0] ch_q,
  output logic              fe_q,
  output logic              pe_q,
  output logic              ovr_q
);
  logic              pend_d, fe_d, pe_d, ovr_d, load;
  logic [CHAR_W-1:0] ch_d;

  always_comb begin
    pend_d = pending;
    ovr_d  = ovr_q;
    load   = 1'b0;
    if (cap) begin
      load   = 1'b1;
      pend_d = 1'b1;
      ovr_d  = pending && !grant;
    end else if (grant) begin
      pend_d = 1'b0;
    end
    ch_d = ch_in;
    fe_d = fe_in;
    pe_d = pe_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ovr_q   <= 1'b0;
      ch_q    <= '0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
    end else begin
      pending <= pend_d;
      ovr_q   <= ovr_d;
      if (load) begin
        ch_q <= ch_d;
        fe_q <= fe_d;
        pe_q <= pe_d;
      end
    end
  end
endmodule

// File: rtl/silo_prio_arb.sv
module silo_prio_arb #(
  parameter int N   = 8,
  parameter int IDX = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   req,
  output logic [N-1:0]   grant,
  output logic [IDX-1:0] grant_idx,
  output logic           any
);
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IDX'(i);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/silo_fifo.sv
module silo_fifo
  import silo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  silo_entry_t       wr_entry,
  input  logic              pop_req,
  output silo_entry_t       rd_entry,
  output logic [CNT_W-1:0]  count,
  output logic              accepted,
  output logic              dropped
);
  silo_entry_t      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             pop_eff, room;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_eff  = pop_req && (count != '0);
    room     = (count < CNT_W'(DEPTH)) || pop_eff;
    accepted = wr_req && room;
    dropped  = wr_req && !room;
    wr_ptr_d = accepted ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_d = pop_eff ? ptr_inc(rd_ptr) : rd_ptr;
    count_d  = count;
    if (accepted && !pop_eff) count_d = count + 1'b1;
    else if (!accepted && pop_eff) count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= wr_entry;
  end

  assign rd_entry = mem[rd_ptr];
endmodule

// File: rtl/silo_irq_gen.sv
module silo_irq_gen #(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count,
  input  logic             rxint_en,
  input  logic             alarm_en,
  output logic             irq
);
  logic reached;

  always_comb begin
    if (alarm_en) reached = (count >= CNT_W'(ALARM_LEVEL));
    else          reached = (count != '0);
    irq = rxint_en && reached;
  end
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import silo_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        line_strobe,
  input  logic [NUM_LINES*CHAR_W-1:0] line_char,
  input  logic [NUM_LINES-1:0]        line_ferr,
  input  logic [NUM_LINES-1:0]        line_perr,
  input  logic [NUM_LINES-1:0]        rx_enable,
  input  logic                        rxint_en,
  input  logic                        alarm_en,
  input  logic                        pop,
  output logic [WORD_W-1:0]           rd_word,
  output logic                        irq
);
  logic [NUM_LINES-1:0] hold_pend, hold_fe, hold_pe, hold_ovr, grant_vec, cap_vec;
  logic [CHAR_W-1:0]    hold_ch [NUM_LINES];
  logic [IDX_W-1:0]     grant_idx;
  logic                 grant_any, fifo_accept, fifo_drop, word_valid;
  logic                 lost_q, lost_d;
  logic [CNT_W-1:0]     fill_level;
  silo_entry_t          wr_entry, head;

  assign cap_vec = line_strobe & rx_enable;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    silo_line_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap_vec[g]),
      .grant   (grant_vec[g]),
      .ch_in   (line_char[g*CHAR_W +: CHAR_W]),
      .fe_in   (line_ferr[g]),
      .pe_in   (line_perr[g]),
      .pending (hold_pend[g]),
      .ch_q    (hold_ch[g]),
      .fe_q    (hold_fe[g]),
      .pe_q    (hold_pe[g]),
      .ovr_q   (hold_ovr[g])
    );
  end

  silo_prio_arb #(.N(NUM_LINES)) u_arb (
    .req       (hold_pend),
    .grant     (grant_vec),
    .grant_idx (grant_idx),
    .any       (grant_any)
  );

  always_comb begin
    wr_entry.ch   = hold_ch[grant_idx];
    wr_entry.fe   = hold_fe[grant_idx];
    wr_entry.pe   = hold_pe[grant_idx];
    wr_entry.ovr  = hold_ovr[grant_idx] | lost_q;
    wr_entry.line = LINE_W'(grant_idx);
  end

  silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (grant_any),
    .wr_entry (wr_entry),
    .pop_req  (pop),
    .rd_entry (head),
    .count    (fill_level),
    .accepted (fifo_accept),
    .dropped  (fifo_drop)
  );

  always_comb begin
    lost_d = lost_q;
    if (fifo_drop)        lost_d = 1'b1;
    else if (fifo_accept) lost_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= lost_d;
  end

  assign word_valid = (fill_level != '0);

  always_comb begin
    if (word_valid)
      rd_word = {1'b1, head.ovr, head.fe, head.pe, 1'b0, head.line, head.ch};
    else
      rd_word = '0;
  end

  silo_irq_gen #(.DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL)) u_irq (
    .count    (fill_level),
    .rxint_en (rxint_en),
    .alarm_en (alarm_en),
    .irq      (irq)
  );
endmodule

// File: rtl/mux_rx_silo_chk.sv
module mux_rx_silo_chk #(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rxint_en,
  input logic                 alarm_en,
  input logic                 irq,
  input logic                 pop,
  input logic                 valid,
  input logic [CNT_W-1:0]     fill,
  input logic                 fifo_wr,
  input logic [NUM_LINES-1:0] grant
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rxint_en |-> !irq);

  assert_irq_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rxint_en && !alarm_en && valid) |-> irq);

  assert_alarm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rxint_en && alarm_en && fill < CNT_W'(ALARM_LEVEL)) |-> !irq);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !valid && !fifo_wr) |=> (fill == '0));

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && valid && !fifo_wr) |=> (fill == $past(fill) - 1'b1));

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind mux_rx_silo mux_rx_silo_chk #(
  .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rxint_en (rxint_en),
  .alarm_en (alarm_en),
  .irq      (irq),
  .pop      (pop),
  .valid    (word_valid),
  .fill     (fill_level),
  .fifo_wr  (fifo_accept),
  .grant    (grant_vec)
);

// File: tb/mux_rx_silo_tb.sv
module mux_rx_silo_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  line_strobe, line_ferr, line_perr, rx_enable;
  logic [63:0] line_char;
  logic        rxint_en, alarm_en, pop;
  logic [15:0] rd_word;
  logic        irq;

  int          n_cmp  = 0;
  int          n_bad  = 0;
  bit          done   = 1'b0;
  logic [15:0] exp_q [$];

  always #4 clk = ~clk;

  mux_rx_silo u_dut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_char(line_char),
    .line_ferr(line_ferr), .line_perr(line_perr), .rx_enable(rx_enable),
    .rxint_en(rxint_en), .alarm_en(alarm_en), .pop(pop), .rd_word(rd_word), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int ln, input logic [7:0] ch,
                                     input bit ovr, input bit fe, input bit pe);
    return {1'b1, ovr, fe, pe, 1'b0, 3'(ln), ch};
  endfunction

  // Driver: present strobes for one cycle, push expected entries in line order.
  task automatic put(input logic [7:0] mask, input logic [63:0] chars,
                     input logic [7:0] fe, input logic [7:0] pe,
                     input logic [7:0] keep, input logic [7:0] ovr);
    line_strobe = mask; line_char = chars; line_ferr = fe; line_perr = pe;
    for (int i = 0; i < 8; i++)
      if (keep[i]) exp_q.push_back(mk(i, chars[i*8 +: 8], ovr[i], fe[i], pe[i]));
    @(negedge clk);
  endtask

  task automatic idle();
    line_strobe = '0; line_ferr = '0; line_perr = '0;
  endtask

  task automatic settle();
    idle();
    repeat (10) @(negedge clk);
  endtask

  // Monitor: compare head word against scoreboard, then pop.
  task automatic read_cmp(input string req);
    logic [15:0] e;
    if (exp_q.size() == 0) e = 16'h0000;
    else e = exp_q.pop_front();
    check(rd_word == e, req, rd_word, e);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() != 0) read_cmp(req);
    check(rd_word == 16'h0, req, rd_word, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pop = 1'b0; rxint_en = 1'b1; alarm_en = 1'b0;
    rx_enable = 8'hFF; line_char = '0;
    idle();
    repeat (3) @(negedge clk);
    // R2 reset state
    check(rd_word == 16'h0, "R2", rd_word, 16'h0);
    check(irq == 1'b0, "R2", {15'h0, irq}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R9 single character, word layout and plain interrupt
    put(8'h08, 64'h41 << 24, 8'h0, 8'h0, 8'h08, 8'h0);
    settle();
    check(irq == 1'b1, "R9", {15'h0, irq}, 16'h1);
    check(rd_word == 16'h8341, "R1", rd_word, 16'h8341);
    read_cmp("R4");
    check(irq == 1'b0, "R9", {15'h0, irq}, 16'h0);

    // R5 pop while empty then normal traffic
    read_cmp("R5");
    read_cmp("R5");
    put(8'h01, 64'h5A, 8'h0, 8'h0, 8'h01, 8'h0);
    settle();
    drain("R5");

    // R6 disabled line ignored
    rx_enable = 8'hDF;
    put(8'h28, (64'h77 << 40) | (64'h33 << 24), 8'h0, 8'h0, 8'h08, 8'h0);
    settle();
    drain("R6");
    rx_enable = 8'hFF;

    // R7 simultaneous strobes lowest line first
    put(8'h52, (64'hC6 << 48) | (64'hC4 << 32) | (64'hC1 << 8), 8'h0, 8'h0, 8'h52, 8'h0);
    settle();
    drain("R7");

    // R11 break and parity error
    put(8'h04, 64'h0, 8'h04, 8'h0, 8'h04, 8'h0);
    put(8'h80, 64'hE5 << 56, 8'h0, 8'h80, 8'h80, 8'h0);
    put(8'h02, 64'h11 << 8, 8'h02, 8'h02, 8'h02, 8'h0);
    settle();
    drain("R11");

    // R10 alarm threshold
    alarm_en = 1'b1;
    for (int i = 0; i < 15; i++) put(8'h01, 64'(i + 8'h20), 8'h0, 8'h0, 8'h01, 8'h0);
    settle();
    check(irq == 1'b0, "R10", {15'h0, irq}, 16'h0);
    put(8'h01, 64'h2F, 8'h0, 8'h0, 8'h01, 8'h0);
    settle();
    check(irq == 1'b1, "R10", {15'h0, irq}, 16'h1);
    rxint_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R9", {15'h0, irq}, 16'h0);
    rxint_en = 1'b1; alarm_en = 1'b0;
    drain("R10");

    // R3 R8 fill to capacity, overflow drop, overrun on next entry
    for (int i = 0; i < 64; i++) put(8'h04, 64'(i) << 16, 8'h0, 8'h0, 8'h04, 8'h0);
    put(8'h04, 64'hEE << 16, 8'h0, 8'h0, 8'h00, 8'h0);
    settle();
    read_cmp("R3");
    put(8'h04, 64'hAB << 16, 8'h0, 8'h0, 8'h04, 8'h04);
    settle();
    // concurrent grant and pop on a full store: character kept
    put(8'h40, 64'hCD << 48, 8'h0, 8'h0, 8'h40, 8'h0);
    idle();
    read_cmp("R8");
    settle();
    drain("R8");

    // R12 holding-stage replacement carries overrun
    put(8'hFF, 64'h1716151413121110, 8'h0, 8'h0, 8'h7F, 8'h0);
    put(8'h80, 64'h99 << 56, 8'h0, 8'h0, 8'h80, 8'h80);
    settle();
    drain("R12");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule